// File: doc/BRIEF.md
# Scrambled Idle Test-Pattern Checker

This block sits behind the receive descrambler of a multi-lane Ethernet PCS and checks the received 66-bit blocks while the link runs in the scrambled-idle test mode. Each valid block is judged as a whole: its 2-bit sync header and its 64-bit descrambled payload must together form the idle control block. When they do not, the block is a mismatch, and a saturating error counter records it.

The check runs only when three conditions hold at once. The lanes must report alignment, software must have enabled the test mode, and the block-valid strobe must be high. A small synchronous register port gives software its controls. A mode register holds the enable bit and the clear bit. A read-only register returns the error count. Reads are registered, so read data appears one clock after the request.

Top module: `scr_idle_checker`

## Requirements
- R1: After reset (`rst_n` low, sampled on a rising edge), the enable and clear bits are 0, the error count is 0 and `reg_rd_data` is 0.
- R2: A block is idle when `rx_hdr` is 2'b10, `rx_payload[7:0]` (the block type) is 8'h1E and `rx_payload[63:8]` (eight 7-bit control codes) is all zero. An idle block never changes the count.
- R3: On each rising edge where `rx_blk_valid`, `rx_aligned` and the enable bit are all 1, the clear bit is 0 and the block is not idle, the count grows by exactly one.
- R4: When `rx_blk_valid` is 0, `rx_aligned` is 0 or the enable bit is 0, the count holds its value whatever the block contents.
- R5: The count saturates at all ones (CNT_W bits wide, default 32) and does not wrap.
- R6: The mode register is at address 0x019. Bit 1 is the enable and bit 2 is the clear. A write takes effect from the next edge on. A read returns those two bits in place and zeros in every other bit.
- R7: While the clear bit is 1, the count is forced to zero on every edge. A mismatch in the same cycle is dropped.
- R8: The count register is at address 0x01A and is read-only. Writes to it, or to any address other than 0x019, change nothing. Its value is read zero-extended to 32 bits.
- R9: When `reg_rd_en` is 1 at a rising edge, `reg_rd_data` takes the value the addressed register held before that edge. An unmapped address reads 0. When `reg_rd_en` is 0, `reg_rd_data` holds its value.
- R10: A block with the idle payload but any header other than 2'b10, or with the idle header and any single payload bit flipped, is a mismatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_hdr | input | 2 | Sync header of the received block |
| rx_payload | input | 64 | Descrambled block payload |
| rx_blk_valid | input | 1 | Block present this cycle |
| rx_aligned | input | 1 | Lane alignment status |
| reg_addr | input | ADDR_W (10) | Register address |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | DATA_W (32) | Register write data |
| reg_rd_en | input | 1 | Register read strobe |
| reg_rd_data | output | DATA_W (32) | Registered read data |

## Verification
The bench goes after the corners where a checker would quietly miscount. Header-only faults and single-bit payload faults at every byte would slip through a design that tests only the block type or only the header. Blocks that arrive with the strobe low, with alignment low or with the mode disabled would inflate the count in a design that gates on just one of those conditions. A clear that overlaps a stream of mismatches would leave a stray count of one if the clear did not win. The counter is driven past all ones to catch a wrap back to zero. Writes to the read-only count register and to unmapped addresses are made, and the read-back shows that a decoder with a loose address compare would corrupt state.

// File: rtl/idlechk_pkg.sv
// Package: shared constants and types of the scrambled idle checker.
// Assumes a 66-bit block split into a 2-bit header and a 64-bit payload,
// with the block type in the low payload byte.
package idlechk_pkg;
    localparam int          HDR_W        = 2;
    localparam int          PAYLOAD_W    = 64;
    localparam int          TYPE_W       = 8;
    localparam int          CODE_W       = 7;
    localparam int          NUM_CODES    = 8;
    localparam logic [1:0]  HDR_CTRL     = 2'b10;
    localparam logic [7:0]  TYPE_IDLE    = 8'h1E;
    localparam logic [6:0]  CODE_IDLE    = 7'h00;
    localparam int          BIT_ENABLE   = 1;
    localparam int          BIT_CLEAR    = 2;

    // Control bits held in the mode register
    typedef struct packed {
        logic clr;
        logic en;
    } mode_t;
endpackage

// File: rtl/idle_block_match.sv
// Module: idle_block_match
// Purely combinational. Decides whether a header/payload pair forms the
// idle control block. Assumes the payload is already descrambled.
module idle_block_match
    import idlechk_pkg::*;
(
    input  logic [HDR_W-1:0]     hdr,
    input  logic [PAYLOAD_W-1:0] payload,
    output logic                 is_idle
);
    localparam int CODE_BASE = TYPE_W;

    logic [NUM_CODES-1:0] code_ok;
    logic                 hdr_ok;
    logic                 type_ok;

    // One comparator per control-code slot
    for (genvar g = 0; g < NUM_CODES; g++) begin : g_code
        assign code_ok[g] =
            (payload[CODE_BASE + g*CODE_W +: CODE_W] == CODE_IDLE);
    end

    // Combine the header, type and code results into one verdict
    always_comb begin
        hdr_ok  = (hdr == HDR_CTRL);
        type_ok = (payload[TYPE_W-1:0] == TYPE_IDLE);
        is_idle = hdr_ok && type_ok && (&code_ok);
    end
endmodule

// File: rtl/err_sat_counter.sv
// Module: err_sat_counter
// Saturating up-counter with a synchronous clear that wins over an
// increment. Assumes one increment request per cycle at most.
module err_sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    logic at_max;

    // Flag the saturation point
    always_comb at_max = (count == CNT_MAX);

    // Count with clear priority and hold at the top
    always_ff @(posedge clk) begin
        if (!rst_n)               count <= '0;
        else if (clr)             count <= '0;
        else if (inc && !at_max)  count <= count + 1'b1;
    end
endmodule

// File: rtl/tp_reg_port.sv
// Module: tp_reg_port
// Register port of the checker. It holds the mode bits and returns
// registered reads of the mode and count registers. Assumes there is one
// access per cycle and that the write and read strobes are independent.
module tp_reg_port
    import idlechk_pkg::*;
#(
    parameter int              ADDR_W    = 10,
    parameter int              DATA_W    = 32,
    parameter int              CNT_W     = 32,
    parameter logic [ADDR_W-1:0] MODE_ADDR = 10'h019,
    parameter logic [ADDR_W-1:0] CNT_ADDR  = 10'h01A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [CNT_W-1:0]  cnt,
    output mode_t             mode,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] rd_next;
    logic              unused_wr_bits;

    // Only the two mode bits are stored; the rest of the write data is dropped
    assign unused_wr_bits = ^wr_data;

    // Mode register update on a write to its address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= '0;
        end else if (wr_en && (addr == MODE_ADDR)) begin
            mode.en  <= wr_data[BIT_ENABLE];
            mode.clr <= wr_data[BIT_CLEAR];
        end
    end

    // Read mux: pick the addressed register value
    always_comb begin
        rd_next = '0;
        if (addr == MODE_ADDR) begin
            rd_next[BIT_ENABLE] = mode.en;
            rd_next[BIT_CLEAR]  = mode.clr;
        end else if (addr == CNT_ADDR) begin
            rd_next[CNT_W-1:0] = cnt;
        end
    end

    // Registered read data, held between reads
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_next;
    end
endmodule

// File: rtl/scr_idle_checker.sv
// Module: scr_idle_checker (top)
// Scrambled idle test-pattern checker. It compares each valid block with
// the idle control block and counts mismatches while the lanes are aligned
// and the test mode is enabled. Assumes CNT_W <= DATA_W.
module scr_idle_checker
    import idlechk_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [HDR_W-1:0]     rx_hdr,
    input  logic [PAYLOAD_W-1:0] rx_payload,
    input  logic                 rx_blk_valid,
    input  logic                 rx_aligned,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_wr_en,
    input  logic [DATA_W-1:0]    reg_wr_data,
    input  logic                 reg_rd_en,
    output logic [DATA_W-1:0]    reg_rd_data
);
    mode_t            mode;
    logic             blk_idle;
    logic             chk_active;
    logic             mismatch;
    logic [CNT_W-1:0] err_cnt;

    idle_block_match u_match (
        .hdr     (rx_hdr),
        .payload (rx_payload),
        .is_idle (blk_idle)
    );

    // Qualify the verdict with the strobe, alignment and mode enable
    always_comb begin
        chk_active = rx_blk_valid && rx_aligned && mode.en;
        mismatch   = chk_active && !blk_idle;
    end

    err_sat_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (mode.clr),
        .inc   (mismatch),
        .count (err_cnt)
    );

    tp_reg_port #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (reg_addr),
        .wr_en   (reg_wr_en),
        .wr_data (reg_wr_data),
        .rd_en   (reg_rd_en),
        .cnt     (err_cnt),
        .mode    (mode),
        .rd_data (reg_rd_data)
    );
endmodule

// File: rtl/scr_idle_checker_sva.sv
// Module: scr_idle_checker_sva
// Checker bound to scr_idle_checker. It watches the count against the
// block inputs and the mode bits, and it watches the register port.
module scr_idle_checker_sva #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        hdr,
    input logic [63:0]       payload,
    input logic              blk_valid,
    input logic              aligned,
    input logic              en,
    input logic              clr,
    input logic [CNT_W-1:0]  cnt,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data
);
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    p_reset_zero_r1: assert property (@(posedge clk)
        !rst_n |=> (cnt == '0 && rd_data == '0));

    p_idle_no_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && hdr == 2'b10 && payload == 64'h1E) |=> cnt == $past(cnt));

    p_step_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && cnt != CMAX) |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));

    p_hold_inactive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !(blk_valid && aligned && en)) |=> cnt == $past(cnt));

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && cnt == CMAX) |=> cnt == CMAX);

    p_mode_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 10'h019) |=> (en == $past(wr_data[1]) && clr == $past(wr_data[2])));

    p_clear_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt == '0);

    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr != 10'h019 && addr != 10'h01A) |=> rd_data == '0);

    p_read_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

bind scr_idle_checker scr_idle_checker_sva #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .hdr       (rx_hdr),
    .payload   (rx_payload),
    .blk_valid (rx_blk_valid),
    .aligned   (rx_aligned),
    .en        (mode.en),
    .clr       (mode.clr),
    .cnt       (err_cnt),
    .addr      (reg_addr),
    .wr_en     (reg_wr_en),
    .wr_data   (reg_wr_data),
    .rd_en     (reg_rd_en),
    .rd_data   (reg_rd_data)
);

// File: tb/scr_idle_checker_tb_top.sv
// Bench: behavioural reference model compared with the read port every clock.
module scr_idle_checker_tb_top;
    localparam int CW = 8;
    localparam logic [9:0] A_MODE = 10'h019;
    localparam logic [9:0] A_CNT  = 10'h01A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  rx_hdr = 2'b10;
    logic [63:0] rx_payload = 64'h1E;
    logic        rx_blk_valid = 1'b0;
    logic        rx_aligned = 1'b0;
    logic [9:0]  reg_addr = '0;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wr_data = '0;
    logic        reg_rd_en = 1'b0;
    logic [31:0] reg_rd_data;

    int    n_chk = 0;
    int    n_fail = 0;
    int    cyc = 0;
    bit    done = 0;
    string phase = "R1";

    // Reference model state
    int          m_cnt = 0;
    bit          m_en = 0;
    bit          m_clr = 0;
    logic [31:0] m_rd = '0;

    always #2 clk = ~clk;

    scr_idle_checker #(.CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .rx_hdr(rx_hdr), .rx_payload(rx_payload),
        .rx_blk_valid(rx_blk_valid), .rx_aligned(rx_aligned),
        .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .reg_rd_en(reg_rd_en), .reg_rd_data(reg_rd_data)
    );

    function automatic bit ref_idle(logic [1:0] h, logic [63:0] p);
        return (h == 2'b10) && (p == 64'h0000_0000_0000_001E);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: reg_rd_data=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock: update model at the edge, compare at the following falling edge
    task automatic step();
        @(posedge clk);
        if (!rst_n) begin
            m_cnt = 0; m_en = 0; m_clr = 0; m_rd = '0;
        end else begin
            if (reg_rd_en) begin
                if (reg_addr == A_MODE)     m_rd = {29'd0, m_clr, m_en, 1'b0};
                else if (reg_addr == A_CNT) m_rd = m_cnt;
                else                        m_rd = '0;
            end
            if (m_clr) m_cnt = 0;
            else if (m_en && rx_aligned && rx_blk_valid && !ref_idle(rx_hdr, rx_payload)
                     && m_cnt < (1 << CW) - 1)
                m_cnt = m_cnt + 1;
            if (reg_wr_en && reg_addr == A_MODE) begin
                m_en  = reg_wr_data[1];
                m_clr = reg_wr_data[2];
            end
        end
        @(negedge clk);
        check(phase, reg_rd_data, m_rd);
    endtask

    task automatic blk(logic v, logic al, logic [1:0] h, logic [63:0] p);
        rx_blk_valid = v; rx_aligned = al; rx_hdr = h; rx_payload = p;
        reg_wr_en = 0; reg_rd_en = 1; reg_addr = A_CNT;
        step();
    endtask

    task automatic wr(logic [9:0] a, logic [31:0] d);
        rx_blk_valid = 0;
        reg_wr_en = 1; reg_addr = a; reg_wr_data = d; reg_rd_en = 0;
        step();
        reg_wr_en = 0;
    endtask

    task automatic rd(logic [9:0] a);
        rx_blk_valid = 0; reg_wr_en = 0; reg_rd_en = 1; reg_addr = a;
        step();
    endtask

    // Watchdog: a hung run is a failed check and still reports
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: cycles=%0d expected<=%0d", cyc, 50000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [63:0] lf = 64'h0123_4567_89AB_CDEF;
        @(negedge clk);
        phase = "R1";
        step(); step();
        rst_n = 1;
        rd(A_CNT); rd(A_MODE);

        phase = "R6";
        wr(A_MODE, 32'hFFFF_FFFB);
        rd(A_MODE);

        phase = "R2";
        for (int i = 0; i < 6; i++) blk(1, 1, 2'b10, 64'h1E);

        phase = "R3";
        for (int i = 0; i < 20; i++) begin
            lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
            blk(1, 1, lf[1:0], lf);
            blk(1, 1, 2'b10, 64'h1E);
        end

        phase = "R10";
        blk(1, 1, 2'b01, 64'h1E);
        blk(1, 1, 2'b11, 64'h1E);
        blk(1, 1, 2'b00, 64'h1E);
        for (int b = 0; b < 64; b += 9) blk(1, 1, 2'b10, 64'h1E ^ (64'd1 << b));
        blk(1, 1, 2'b10, 64'h1E ^ (64'd1 << 63));

        phase = "R4";
        blk(0, 1, 2'b01, 64'hDEAD);
        blk(1, 0, 2'b00, 64'hBEEF);
        wr(A_MODE, 32'h0);
        blk(1, 1, 2'b11, 64'h5555);
        rd(A_MODE);
        wr(A_MODE, 32'h2);

        phase = "R8";
        wr(A_CNT, 32'h0);
        wr(10'h11A, 32'h4);
        rd(A_CNT); rd(A_MODE);

        phase = "R7";
        wr(A_MODE, 32'h6);
        for (int i = 0; i < 4; i++) blk(1, 1, 2'b01, 64'h0);
        rd(A_MODE);
        wr(A_MODE, 32'h2);
        rd(A_CNT);

        phase = "R5";
        for (int i = 0; i < 300; i++) blk(1, 1, 2'b00, 64'h0);
        rd(A_CNT);

        phase = "R9";
        rd(10'h000); rd(10'h3FF);
        reg_rd_en = 0; reg_addr = A_CNT; step(); step();
        rd(A_MODE);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule